// File: doc/BRIEF.md
# Inbound DMA Address Translator

This block turns a 64-bit address arriving from one of two downstream peripheral ports into a 64-bit system address. The address range in which the request falls picks one of five rules:

- **64-bit direct**: the address carries its own attribute bits.
- **32-bit direct**: a per-port upper-bits register is spliced onto the low bits.
- **32-bit table-mapped**: 256 KB pages.
- **40-bit table-mapped**: 64 MB pages.
- **40-bit super-page**: 16 GB pages, split between the two ports.

Alongside the system address the block reports a barrier flag, an MSI flag and a fault flag.

Software fills the two direct-map registers and the two translation tables through a write-only port made of select, index, data and write-enable. The block decides nothing about where mappings go; it only applies what has been written. A lookup is presented with `in_valid`. Its result appears registered one clock later. There is no state machine: the only sequential state is the configuration storage and the output register.

Top module: `dma_xlat`

## Requirements
- R1: When address bit 63 is set the mode is 64-bit direct (`out_mode` = 1). The system address is address bits 53:0 with bits 63:54 zero, `out_barrier` is address bit 62 and `out_msi` is address bit 61.
- R2: In 64-bit direct mode, a nonzero value in address bits 60:54 sets `out_fault`.
- R3: Addresses 0x8000_0000 to 0xFFFF_FFFF use 32-bit direct mode (`out_mode` = 2). The system address is the selected port's direct-map register (bits 63:30, written from `cfg_data[63:30]`) joined with address bits 29:0. `out_barrier` is address bit 30.
- R4: Addresses 0x0 to 0x7FFF_FFFF use 32-bit table mode (`out_mode` = 3) on the shared table. The index is address bits 29:18 and `out_barrier` is address bit 30.
- R5: In 32-bit table mode, an index below 64 (the super-page entries) or at or above the shared table depth of 128 sets `out_fault`.
- R6: Addresses 0x40_0000_0000 to 0x7F_FFFF_FFFF use the 64-entry 40-bit table (`out_mode` = 4). The index is address bits 37:26, and an index of 64 or more faults. Neither 40-bit mode ever raises `out_barrier`.
- R7: Addresses 0x80_0000_0000 to 0xFF_FFFF_FFFF use super-pages (`out_mode` = 5). The shared entry used is `port`×32 + address bits 38:34, so port 0 owns entries 0–31 and port 1 owns entries 32–63.
- R8: A table entry is valid when its bit 63 is set; its bit 62 is the MSI flag. The system address is the entry's bits 61:0 with the page-offset bits cleared, plus the page offset of the address. A lookup that hits an invalid entry faults.
- R9: An address outside every window gives `out_mode` = 0 and `out_fault` = 1. Whenever `out_fault` is 1, `out_addr`, `out_barrier` and `out_msi` are 0.
- R10: The outputs for a lookup appear on the first rising edge after `in_valid` is sampled, and `out_valid` follows `in_valid` with exactly one cycle of delay.
- R11: `cfg_sel` codes are 0 for the direct-map registers (port chosen by `cfg_idx[0]`), 1 for the shared table and 2 for the 40-bit table. A table write whose index is at or beyond that table's depth is ignored.
- R12: After reset all outputs are 0 and every table entry and direct-map register is 0, so table lookups fault until entries are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 64 | Inbound bus address |
| in_port | input | 1 | Originating port (0 or 1) |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target select |
| cfg_idx | input | 7 | Entry index or port number |
| cfg_data | input | 64 | Configuration write data |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Translated system address |
| out_mode | output | 3 | Translation mode taken |
| out_barrier | output | 1 | Barrier attribute |
| out_msi | output | 1 | MSI attribute |
| out_fault | output | 1 | Translation fault |

## Verification
Each window is tried with at least one address that maps cleanly and one that must fault:

- **64-bit direct**: plain, attribute-carrying and reserved-bit addresses tell the direct rule apart from its reserved-bit guard.
- **32-bit direct**: both ports with different direct-map values show the port select.
- **32-bit table**: the barrier bit and the MSI entry are exercised, and the reserved low entries and the past-the-end index separate the allowed range from the two forbidden ranges.
- **Super-page**: the same page offset is presented from both ports, with only one port's entry written, which shows the partition.
- **Holes and state**: addresses between windows, an empty table straight after reset, and an out-of-range table write followed by a lookup of the aliased entry cover the remaining corners.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [2:0] {
        XM_NONE  = 3'd0,
        XM_DIR64 = 3'd1,
        XM_DIR32 = 3'd2,
        XM_TBL32 = 3'd3,
        XM_TBL40 = 3'd4,
        XM_SUPER = 3'd5
    } xmode_e;

    typedef enum logic [1:0] {
        CS_DIRMAP = 2'd0,
        CS_SHARED = 2'd1,
        CS_TBL40  = 2'd2,
        CS_NONE   = 2'd3
    } cfg_sel_e;

    // page shifts of the three table modes and the direct-32 split point
    localparam int PG32_SH = 18;
    localparam int PG40_SH = 26;
    localparam int PGSP_SH = 34;
    localparam int D32_SH  = 30;

    localparam int ENT_VALID = 63;
    localparam int ENT_MSI   = 62;

    // entry bits that can carry a frame (flag bits excluded)
    localparam logic [63:0] FRAME_BITS = 64'h3FFF_FFFF_FFFF_FFFF;

endpackage

// File: rtl/xlat_window_dec.sv
module xlat_window_dec
    import xlat_pkg::*;
#(
    parameter int SH_DEPTH       = 128,
    parameter int T40_DEPTH      = 64,
    parameter int SUPER_PER_PORT = 32,
    localparam int SH_AW         = $clog2(SH_DEPTH),
    localparam int T40_AW        = $clog2(T40_DEPTH)
) (
    input  logic [63:18]       addr_hi,
    input  logic               port,
    output xmode_e             mode,
    output logic               idx_fault,
    output logic [SH_AW-1:0]   sh_idx,
    output logic [T40_AW-1:0]  t40_idx
);

    localparam int          SUPER_RSV = 2 * SUPER_PER_PORT;
    localparam logic [11:0] RSV12     = 12'(SUPER_RSV);
    localparam logic [11:0] SHD12     = 12'(SH_DEPTH);
    localparam logic [11:0] T40D12    = 12'(T40_DEPTH);
    localparam logic [5:0]  SPP6      = 6'(SUPER_PER_PORT);

    logic        hit_d64, hit_d32, hit_m32, hit_m40, hit_sp;
    logic [11:0] pg32, pg40;
    logic [4:0]  pgsp;
    logic [SH_AW-1:0] sp_base;

    always_comb begin
        hit_d64 = addr_hi[63];
        hit_d32 = (addr_hi[63:32] == '0) && addr_hi[31];
        hit_m32 = (addr_hi[63:31] == '0);
        hit_m40 = (addr_hi[63:40] == '0) && (addr_hi[39:38] == 2'b01);
        hit_sp  = (addr_hi[63:40] == '0) && addr_hi[39];

        pg32 = addr_hi[29:18];
        pg40 = addr_hi[37:26];
        pgsp = addr_hi[38:34];
        sp_base = port ? SH_AW'(SUPER_PER_PORT) : '0;

        mode      = XM_NONE;
        idx_fault = 1'b0;
        sh_idx    = '0;
        t40_idx   = '0;

        if (hit_d64) begin
            mode      = XM_DIR64;
            idx_fault = |addr_hi[60:54];
        end else if (hit_d32) begin
            mode = XM_DIR32;
        end else if (hit_m32) begin
            mode      = XM_TBL32;
            idx_fault = (pg32 < RSV12) || (pg32 >= SHD12);
            sh_idx    = pg32[SH_AW-1:0];
        end else if (hit_m40) begin
            mode      = XM_TBL40;
            idx_fault = (pg40 >= T40D12);
            t40_idx   = pg40[T40_AW-1:0];
        end else if (hit_sp) begin
            mode      = XM_SUPER;
            idx_fault = ({1'b0, pgsp} >= SPP6);
            sh_idx    = sp_base + SH_AW'(pgsp);
        end
    end

endmodule

// File: rtl/xlat_entry_table.sv
module xlat_entry_table #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 7,
    parameter int DW    = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]  wdata,
    input  logic [AW-1:0]  ridx,
    output logic [DW-1:0]  rdata
);

    localparam logic [IDX_W:0] DEPTH_W = (IDX_W+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic          wr_ok;

    assign wr_ok = we && ({1'b0, widx} < DEPTH_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[AW'(widx)] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/dma_xlat.sv
module dma_xlat
    import xlat_pkg::*;
#(
    parameter int SH_DEPTH       = 128,
    parameter int T40_DEPTH      = 64,
    parameter int SUPER_PER_PORT = 32,
    parameter int CFG_IDX_W      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [63:0]          in_addr,
    input  logic                 in_port,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [63:0]          cfg_data,
    output logic                 out_valid,
    output logic [63:0]          out_addr,
    output logic [2:0]           out_mode,
    output logic                 out_barrier,
    output logic                 out_msi,
    output logic                 out_fault
);

    localparam int SH_AW  = $clog2(SH_DEPTH);
    localparam int T40_AW = $clog2(T40_DEPTH);

    localparam logic [63:0] OFF32 = (64'd1 << PG32_SH) - 64'd1;
    localparam logic [63:0] OFF40 = (64'd1 << PG40_SH) - 64'd1;
    localparam logic [63:0] OFFSP = (64'd1 << PGSP_SH) - 64'd1;

    xmode_e              dec_mode;
    logic                dec_fault;
    logic [SH_AW-1:0]    sh_idx;
    logic [T40_AW-1:0]   t40_idx;
    logic [63:0]         sh_ent, t40_ent;
    logic [63:D32_SH]    dirmap [2];

    logic [63:0] nx_addr;
    logic        nx_bar, nx_msi, nx_fault;

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    xlat_window_dec #(
        .SH_DEPTH(SH_DEPTH), .T40_DEPTH(T40_DEPTH), .SUPER_PER_PORT(SUPER_PER_PORT)
    ) u_dec (
        .addr_hi  (in_addr[63:18]),
        .port     (in_port),
        .mode     (dec_mode),
        .idx_fault(dec_fault),
        .sh_idx   (sh_idx),
        .t40_idx  (t40_idx)
    );

    xlat_entry_table #(.DEPTH(SH_DEPTH), .IDX_W(CFG_IDX_W), .DW(64)) u_shared (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we && sel == CS_SHARED), .widx(cfg_idx), .wdata(cfg_data),
        .ridx(sh_idx), .rdata(sh_ent)
    );

    xlat_entry_table #(.DEPTH(T40_DEPTH), .IDX_W(CFG_IDX_W), .DW(64)) u_tbl40 (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we && sel == CS_TBL40), .widx(cfg_idx), .wdata(cfg_data),
        .ridx(t40_idx), .rdata(t40_ent)
    );

    // per-port direct-map registers
    for (genvar p = 0; p < 2; p++) begin : g_dirmap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dirmap[p] <= '0;
            else if (cfg_we && sel == CS_DIRMAP && cfg_idx[0] == 1'(p))
                dirmap[p] <= cfg_data[63:D32_SH];
        end
    end

    // translation rule per mode
    always_comb begin
        nx_addr  = '0;
        nx_bar   = 1'b0;
        nx_msi   = 1'b0;
        nx_fault = dec_fault;
        unique case (dec_mode)
            XM_DIR64: begin
                nx_addr = {10'b0, in_addr[53:0]};
                nx_bar  = in_addr[62];
                nx_msi  = in_addr[61];
            end
            XM_DIR32: begin
                nx_addr = {dirmap[in_port], in_addr[D32_SH-1:0]};
                nx_bar  = in_addr[D32_SH];
            end
            XM_TBL32: begin
                nx_addr  = (sh_ent & FRAME_BITS & ~OFF32) | (in_addr & OFF32);
                nx_bar   = in_addr[D32_SH];
                nx_msi   = sh_ent[ENT_MSI];
                nx_fault = dec_fault || !sh_ent[ENT_VALID];
            end
            XM_TBL40: begin
                nx_addr  = (t40_ent & FRAME_BITS & ~OFF40) | (in_addr & OFF40);
                nx_msi   = t40_ent[ENT_MSI];
                nx_fault = dec_fault || !t40_ent[ENT_VALID];
            end
            XM_SUPER: begin
                nx_addr  = (sh_ent & FRAME_BITS & ~OFFSP) | (in_addr & OFFSP);
                nx_msi   = sh_ent[ENT_MSI];
                nx_fault = dec_fault || !sh_ent[ENT_VALID];
            end
            default: nx_fault = 1'b1;
        endcase
        if (nx_fault) begin
            nx_addr = '0;
            nx_bar  = 1'b0;
            nx_msi  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_addr    <= '0;
            out_mode    <= '0;
            out_barrier <= 1'b0;
            out_msi     <= 1'b0;
            out_fault   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr    <= nx_addr;
                out_mode    <= dec_mode;
                out_barrier <= nx_bar;
                out_msi     <= nx_msi;
                out_fault   <= nx_fault;
            end
        end
    end

    // R9
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_addr == '0 && !out_barrier && !out_msi));

    // R10
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    no_barrier_40_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_mode == 3'd4 || out_mode == 3'd5)) |-> !out_barrier);

    // R9
    hole_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 3'd0) |-> out_fault);

    // R3
    d32_no_msi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 3'd2) |-> !out_msi);

endmodule

// File: tb/tb_dma_xlat.sv
module tb_dma_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        in_port = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [6:0]  cfg_idx = '0;
    logic [63:0] cfg_data = '0;
    logic        out_valid, out_barrier, out_msi, out_fault;
    logic [63:0] out_addr;
    logic [2:0]  out_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_xlat dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_port(in_port), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .out_valid(out_valid), .out_addr(out_addr),
        .out_mode(out_mode), .out_barrier(out_barrier), .out_msi(out_msi),
        .out_fault(out_fault)
    );

    typedef struct packed {
        logic [63:0] addr;
        logic        port;
        logic [63:0] exp_addr;
        logic [2:0]  mode;
        logic        bar;
        logic        msi;
        logic        flt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{64'h8000_0000_1234_5678, 1'b0, 64'h0000_0000_1234_5678, 3'd1, 1'b0, 1'b0, 1'b0, 4'd1}, // R1
        '{64'hE02A_BCDE_F012_3456, 1'b0, 64'h002A_BCDE_F012_3456, 3'd1, 1'b1, 1'b1, 1'b0, 4'd1}, // R1
        '{64'h8040_0000_0000_0000, 1'b0, 64'h0,                   3'd1, 1'b0, 1'b0, 1'b1, 4'd2}, // R2
        '{64'h0000_0000_8123_4567, 1'b0, 64'h0000_0012_C123_4567, 3'd2, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
        '{64'h0000_0000_C000_0010, 1'b1, 64'h0000_0040_0000_0010, 3'd2, 1'b1, 1'b0, 1'b0, 4'd3}, // R3
        '{64'h0000_0000_0101_2345, 1'b0, 64'h0000_0001_2345_2345, 3'd3, 1'b0, 1'b0, 1'b0, 4'd4}, // R4
        '{64'h0000_0000_4104_0010, 1'b0, 64'h0000_0002_0000_0010, 3'd3, 1'b1, 1'b1, 1'b0, 4'd4}, // R4
        '{64'h0000_0000_0108_0000, 1'b0, 64'h0,                   3'd3, 1'b0, 1'b0, 1'b1, 4'd8}, // R8
        '{64'h0000_0000_000C_0000, 1'b0, 64'h0,                   3'd3, 1'b0, 1'b0, 1'b1, 4'd5}, // R5
        '{64'h0000_0000_0200_0000, 1'b0, 64'h0,                   3'd3, 1'b0, 1'b0, 1'b1, 4'd5}, // R5
        '{64'h0000_0040_0812_3456, 1'b0, 64'h0000_0000_1C12_3456, 3'd4, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
        '{64'h0000_0041_0000_0000, 1'b0, 64'h0,                   3'd4, 1'b0, 1'b0, 1'b1, 4'd6}, // R6
        '{64'h0000_008D_2345_6789, 1'b0, 64'h0000_0041_2345_6789, 3'd5, 1'b0, 1'b0, 1'b0, 4'd7}, // R7
        '{64'h0000_0084_0000_0ABC, 1'b1, 64'h0000_0100_0000_0ABC, 3'd5, 1'b0, 1'b0, 1'b0, 4'd7}, // R7
        '{64'h0000_008C_0000_0000, 1'b1, 64'h0,                   3'd5, 1'b0, 1'b0, 1'b1, 4'd7}, // R7
        '{64'h0000_0084_0000_0000, 1'b0, 64'h0,                   3'd5, 1'b0, 1'b0, 1'b1, 4'd7}, // R7
        '{64'h0000_0001_0000_0000, 1'b0, 64'h0,                   3'd0, 1'b0, 1'b0, 1'b1, 4'd9}, // R9
        '{64'h4000_0000_0000_0000, 1'b0, 64'h0,                   3'd0, 1'b0, 1'b0, 1'b1, 4'd9}  // R9
    };

    task automatic cfg_write(input logic [1:0] s, input logic [6:0] i, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_idx = i; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup_check(input string tag, input logic [63:0] a, input logic p,
                                input logic [63:0] ea, input logic [2:0] em,
                                input logic eb, input logic ems, input logic ef);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_port = p;
        @(negedge clk);
        in_valid = 1'b0;
        n_chk++;
        if (!out_valid || out_addr !== ea || out_mode !== em ||
            out_barrier !== eb || out_msi !== ems || out_fault !== ef) begin
            n_bad++;
            $display("FAIL %s addr=%h: got v=%b a=%h m=%0d b=%b s=%b f=%b exp v=1 a=%h m=%0d b=%b s=%b f=%b",
                     tag, a, out_valid, out_addr, out_mode, out_barrier, out_msi, out_fault,
                     ea, em, eb, ems, ef);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state of the outputs
        n_chk++;
        if (out_valid !== 1'b0 || out_addr !== '0 || out_mode !== '0 || out_fault !== 1'b0 ||
            out_barrier !== 1'b0 || out_msi !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 reset outputs: v=%b a=%h m=%0d f=%b exp all zero",
                     out_valid, out_addr, out_mode, out_fault);
        end
        rst_n = 1'b1;
        // R12 empty tables fault before any write
        lookup_check("R12 empty 40-bit table", 64'h0000_0040_0812_3456, 1'b0,
                     64'h0, 3'd4, 1'b0, 1'b0, 1'b1);
        lookup_check("R12 empty shared table", 64'h0000_0000_0101_2345, 1'b0,
                     64'h0, 3'd3, 1'b0, 1'b0, 1'b1);

        // R11 configuration through the select codes
        cfg_write(2'd0, 7'd0, 64'h0000_0012_C000_0000);
        cfg_write(2'd0, 7'd1, 64'h0000_0040_0000_0000);
        cfg_write(2'd1, 7'd64, 64'h8000_0001_2344_0000);
        cfg_write(2'd1, 7'd65, 64'hC000_0002_0000_0000);
        cfg_write(2'd1, 7'd3,  64'h8000_0040_0000_0000);
        cfg_write(2'd1, 7'd33, 64'h8000_0100_0000_0000);
        cfg_write(2'd2, 7'd2,  64'h8000_0000_1C00_0000);

        for (int k = 0; k < NV; k++) begin
            lookup_check($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].addr, VECS[k].port,
                         VECS[k].exp_addr, VECS[k].mode, VECS[k].bar, VECS[k].msi, VECS[k].flt);
        end

        // R11 write beyond 40-bit table depth (index 66) must not alias onto entry 2
        cfg_write(2'd2, 7'd66, 64'h8000_0000_FC00_0000);
        lookup_check("R11 out-of-range write ignored", 64'h0000_0040_0812_3456, 1'b0,
                     64'h0000_0000_1C12_3456, 3'd4, 1'b0, 1'b0, 1'b0);
        // R11 select code 3 writes nothing: direct-map port 0 unchanged
        cfg_write(2'd3, 7'd0, 64'hFFFF_FFFF_C000_0000);
        lookup_check("R11 unused select ignored", 64'h0000_0000_8123_4567, 1'b0,
                     64'h0000_0012_C123_4567, 3'd2, 1'b0, 1'b0, 1'b0);

        // R10 no request -> no valid on the next cycle
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 idle valid: got %b exp 0", out_valid);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule